// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a multicycle load/store processor. It holds one of ten numbered steps in a 4-bit state register. Every clock cycle it presents the complete set of datapath control points: ten single-bit enables and three 2-bit selects, 16 bits in total. The outputs depend only on the current step. The opcode is read only when choosing the next step, so the opcode has no combinational path to any control output.

Every instruction begins with the same two steps. The fetch step loads the instruction register and advances the PC by 4. The decode step reads the source registers and precomputes the branch target. After decode, the controller branches on the opcode. Loads take five cycles, stores and register-register operations take four, and branches and jumps take three. Opcodes the controller does not recognise send it back to fetch straight after decode.

Top module: `mcCtrlFsm`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge puts the controller in the fetch step. This holds even when reset arrives in the middle of an instruction, and the fetch control word is visible after that edge.
- R2: Every instruction starts with a fetch step followed by a decode step.
  - Fetch word: memRead=1, irWrite=1, pcWrite=1, aluSrcB=01, aluOp=00, pcSrc=00, all others 0.
  - Decode word: aluSrcB=11, aluOp=00, all others 0.
- R3: Load (opcode 100011) runs five steps.
  - Fetch, then decode.
  - Address: aluSrcA=1, aluSrcB=10, aluOp=00.
  - Read: memRead=1, addrSel=1.
  - Write-back: regWrite=1, regSrcMem=1, regDstRd=0.
  - Then fetch.
- R4: Store (opcode 101011) runs four steps.
  - Fetch, then decode.
  - Address step (same word as in R3).
  - Write: memWrite=1, addrSel=1.
  - Then fetch.
- R5: Register-register (opcode 000000) runs four steps.
  - Fetch, then decode.
  - Execute: aluSrcA=1, aluSrcB=00, aluOp=10.
  - Complete: regWrite=1, regDstRd=1, regSrcMem=0.
  - Then fetch.
- R6: Branch-if-equal (opcode 000100) runs three steps.
  - Fetch, then decode.
  - Branch: aluSrcA=1, aluSrcB=00, aluOp=01, pcWriteCond=1, pcSrc=01.
  - Then fetch.
- R7: Jump (opcode 000010) runs three steps.
  - Fetch, then decode.
  - Jump: pcWrite=1, pcSrc=10.
  - Then fetch.
- R8: The opcode is consulted only when leaving the decode step and the address step. Opcode values applied during any other step do not change the sequence.
- R9: Any opcode other than the five above, seen in the decode step, returns the controller to fetch at the next edge.
- R10: memRead and memWrite are never both 1, and pcWrite and pcWriteCond are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset to the fetch step |
| opcode | input | 6 | Opcode field of the instruction register |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write when the ALU result is zero |
| addrSel | output | 1 | Memory address: 0 = PC, 1 = ALU output register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register load |
| regSrcMem | output | 1 | Register write data: 0 = ALU output register, 1 = memory data register |
| regDstRd | output | 1 | Destination register: 0 = rt field, 1 = rd field |
| regWrite | output | 1 | Register file write |
| aluSrcA | output | 1 | First ALU operand: 0 = PC, 1 = register A |
| aluOp | output | 2 | 00 add, 01 subtract, 10 use function code |
| aluSrcB | output | 2 | 00 register B, 01 constant 4, 10 sign-extended immediate, 11 immediate shifted left 2 |
| pcSrc | output | 2 | 00 ALU result, 01 branch target, 10 jump address |

## Verification
The bench builds the controller with its default parameters: a 6-bit opcode field and the five default opcode encodings. With these values all ten steps can be reached, and the full 16-bit control word is compared in every cycle of each instruction path. The bench also reaches the unrecognised-opcode return, a reset arriving mid-load, and opcode changes in steps where the opcode must be ignored. Back-to-back instructions confirm that each completion step hands over cleanly to the next fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_MRD    = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MWR    = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RDONE  = 4'd7,
    ST_BR     = 4'd8,
    ST_JMP    = 4'd9
  } stepT;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_IMM4 = 2'b11;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_OUT  = 2'b01;
  localparam logic [1:0] PCS_JUMP = 2'b10;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       addrSel;
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       regSrcMem;
    logic       regDstRd;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluOp;
    logic [1:0] aluSrcB;
    logic [1:0] pcSrc;
  } ctrlWordT;

endpackage

// File: rtl/mcStepSeq.sv
module mcStepSeq
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output stepT            step
);

  stepT stepNext;

  // Dispatch out of decode and address steps; all completion steps return to fetch.
  always_comb begin
    stepNext = ST_FETCH;
    unique case (step)
      ST_FETCH:  stepNext = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) stepNext = ST_ADDR;
        else if (opcode == OP_RTYPE)                 stepNext = ST_EXEC;
        else if (opcode == OP_BEQ)                   stepNext = ST_BR;
        else if (opcode == OP_JUMP)                  stepNext = ST_JMP;
        else                                         stepNext = ST_FETCH;
      end
      ST_ADDR:   stepNext = (opcode == OP_LOAD) ? ST_MRD : ST_MWR;
      ST_MRD:    stepNext = ST_LDWB;
      ST_EXEC:   stepNext = ST_RDONE;
      default:   stepNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_FETCH;
    else     step <= stepNext;
  end

endmodule

// File: rtl/mcCtrlDecode.sv
module mcCtrlDecode
  import mc_ctrl_pkg::*;
(
  input  stepT     step,
  output ctrlWordT word
);

  always_comb begin
    word         = '0;
    word.aluOp   = ALU_ADD;
    word.aluSrcB = SRCB_REG;
    word.pcSrc   = PCS_ALU;
    unique case (step)
      ST_FETCH: begin
        word.memRead = 1'b1;
        word.irWrite = 1'b1;
        word.pcWrite = 1'b1;
        word.aluSrcB = SRCB_FOUR;
      end
      ST_DECODE: word.aluSrcB = SRCB_IMM4;
      ST_ADDR: begin
        word.aluSrcA = 1'b1;
        word.aluSrcB = SRCB_IMM;
      end
      ST_MRD: begin
        word.memRead = 1'b1;
        word.addrSel = 1'b1;
      end
      ST_LDWB: begin
        word.regWrite  = 1'b1;
        word.regSrcMem = 1'b1;
      end
      ST_MWR: begin
        word.memWrite = 1'b1;
        word.addrSel  = 1'b1;
      end
      ST_EXEC: begin
        word.aluSrcA = 1'b1;
        word.aluOp   = ALU_FUNC;
      end
      ST_RDONE: begin
        word.regWrite = 1'b1;
        word.regDstRd = 1'b1;
      end
      ST_BR: begin
        word.aluSrcA     = 1'b1;
        word.aluOp       = ALU_SUB;
        word.pcWriteCond = 1'b1;
        word.pcSrc       = PCS_OUT;
      end
      ST_JMP: begin
        word.pcWrite = 1'b1;
        word.pcSrc   = PCS_JUMP;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/mcCtrlFsm.sv
module mcCtrlFsm
  import mc_ctrl_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'b000000,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'b000010,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'b000100,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011,
  parameter logic [OP_W-1:0] OP_STORE = 6'b101011
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic            pcWrite,
  output logic            pcWriteCond,
  output logic            addrSel,
  output logic            memRead,
  output logic            memWrite,
  output logic            irWrite,
  output logic            regSrcMem,
  output logic            regDstRd,
  output logic            regWrite,
  output logic            aluSrcA,
  output logic [1:0]      aluOp,
  output logic [1:0]      aluSrcB,
  output logic [1:0]      pcSrc
);

  stepT     step;
  ctrlWordT word;

  mcStepSeq #(
    .OP_W(OP_W), .OP_RTYPE(OP_RTYPE), .OP_JUMP(OP_JUMP),
    .OP_BEQ(OP_BEQ), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)
  ) i_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .step(step)
  );

  mcCtrlDecode i_dec (.step(step), .word(word));

  assign pcWrite     = word.pcWrite;
  assign pcWriteCond = word.pcWriteCond;
  assign addrSel     = word.addrSel;
  assign memRead     = word.memRead;
  assign memWrite    = word.memWrite;
  assign irWrite     = word.irWrite;
  assign regSrcMem   = word.regSrcMem;
  assign regDstRd    = word.regDstRd;
  assign regWrite    = word.regWrite;
  assign aluSrcA     = word.aluSrcA;
  assign aluOp       = word.aluOp;
  assign aluSrcB     = word.aluSrcB;
  assign pcSrc       = word.pcSrc;

endmodule

// File: rtl/mcCtrlFsm_chk.sv
module mcCtrlFsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       pcWrite,
  input logic       pcWriteCond,
  input logic       addrSel,
  input logic       memRead,
  input logic       memWrite,
  input logic       irWrite,
  input logic       regSrcMem,
  input logic       regDstRd,
  input logic       regWrite,
  input logic       aluSrcA,
  input logic [1:0] aluOp,
  input logic [1:0] aluSrcB,
  input logic [1:0] pcSrc
);

  // R1: first cycle out of reset is a fetch
  p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irWrite && memRead && pcWrite));

  // R2: fetch is always followed by decode
  p_decode_follows_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (!irWrite && !aluSrcA && aluSrcB == 2'b11 && aluOp == 2'b00));

  // R3, R4: the address step leads to a memory access through the ALU output address
  p_addr_then_access_r3: assert property (@(posedge clk) disable iff (rst)
    (aluSrcA && aluSrcB == 2'b10) |=> (addrSel && (memRead || memWrite)));

  // R5: execute is followed by a write to the rd register from the ALU
  p_exec_then_done_r5: assert property (@(posedge clk) disable iff (rst)
    (aluOp == 2'b10) |=> (regWrite && regDstRd && !regSrcMem));

  // R6, R7: completion steps return to fetch
  p_done_returns_r6: assert property (@(posedge clk) disable iff (rst)
    (regWrite || memWrite || pcWriteCond || (pcWrite && pcSrc == 2'b10)) |=> irWrite);

  // R10: memory strobes and PC writes are exclusive
  p_mem_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));
  p_pc_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(pcWrite && pcWriteCond));

endmodule

bind mcCtrlFsm mcCtrlFsm_chk i_chk (
  .clk(clk), .rst(rst), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
  .addrSel(addrSel), .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
  .regSrcMem(regSrcMem), .regDstRd(regDstRd), .regWrite(regWrite),
  .aluSrcA(aluSrcA), .aluOp(aluOp), .aluSrcB(aluSrcB), .pcSrc(pcSrc)
);

// File: tb/test_mcCtrlFsm.sv
module test_mcCtrlFsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pcWrite, pcWriteCond, addrSel, memRead, memWrite, irWrite;
  logic       regSrcMem, regDstRd, regWrite, aluSrcA;
  logic [1:0] aluOp, aluSrcB, pcSrc;

  int applied = 0;
  int bad = 0;
  int cycles = 0;

  localparam logic [5:0] C_RTYPE = 6'b000000;
  localparam logic [5:0] C_JUMP  = 6'b000010;
  localparam logic [5:0] C_BEQ   = 6'b000100;
  localparam logic [5:0] C_LOAD  = 6'b100011;
  localparam logic [5:0] C_STORE = 6'b101011;

  always #10 clk = ~clk;

  mcCtrlFsm i_mcCtrlFsm (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .addrSel(addrSel),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
    .regSrcMem(regSrcMem), .regDstRd(regDstRd), .regWrite(regWrite),
    .aluSrcA(aluSrcA), .aluOp(aluOp), .aluSrcB(aluSrcB), .pcSrc(pcSrc)
  );

  // Expected control word per step, built from the requirement text.
  // Bit order: pcWrite pcWriteCond addrSel memRead memWrite irWrite
  //            regSrcMem regDstRd regWrite aluSrcA aluOp aluSrcB pcSrc
  function automatic logic [15:0] expWord(input int s);
    logic pw, pwc, as, mr, mw, ir, rsm, rdd, rw, sa;
    logic [1:0] op, sb, ps;
    {pw, pwc, as, mr, mw, ir, rsm, rdd, rw, sa} = '0;
    op = 2'b00; sb = 2'b00; ps = 2'b00;
    case (s)
      0: begin mr = 1; ir = 1; pw = 1; sb = 2'b01; end
      1: sb = 2'b11;
      2: begin sa = 1; sb = 2'b10; end
      3: begin mr = 1; as = 1; end
      4: begin rw = 1; rsm = 1; end
      5: begin mw = 1; as = 1; end
      6: begin sa = 1; op = 2'b10; end
      7: begin rw = 1; rdd = 1; end
      8: begin sa = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      9: begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {pw, pwc, as, mr, mw, ir, rsm, rdd, rw, sa, op, sb, ps};
  endfunction

  function automatic logic [15:0] gotWord();
    return {pcWrite, pcWriteCond, addrSel, memRead, memWrite, irWrite,
            regSrcMem, regDstRd, regWrite, aluSrcA, aluOp, aluSrcB, pcSrc};
  endfunction

  task automatic checkStep(input string req, input int s);
    logic [15:0] g;
    g = gotWord();
    applied++;
    if (g !== expWord(s)) begin
      bad++;
      $display("FAIL %s step %0d: got %h expected %h", req, s, g, expWord(s));
    end
    // R10: exclusivity checked at every sampled cycle
    applied++;
    if ((memRead && memWrite) || (pcWrite && pcWriteCond)) begin
      bad++;
      $display("FAIL R10: got rd/wr=%b%b pc/cond=%b%b expected no overlap",
               memRead, memWrite, pcWrite, pcWriteCond);
    end
  endtask

  task automatic runPath(input string req, input logic [5:0] op,
                         input int n, input int st[5]);
    opcode = op;
    for (int i = 0; i < n; i++) begin
      checkStep(req, st[i]);
      @(negedge clk);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    checkStep("R1", 0);
  endtask

  task automatic testLoad();   runPath("R3", C_LOAD,  5, '{0, 1, 2, 3, 4}); endtask
  task automatic testStore();  runPath("R4", C_STORE, 4, '{0, 1, 2, 5, 0}); endtask
  task automatic testRtype();  runPath("R5", C_RTYPE, 4, '{0, 1, 6, 7, 0}); endtask
  task automatic testBranch(); runPath("R6", C_BEQ,   3, '{0, 1, 8, 0, 0}); endtask
  task automatic testJump();   runPath("R7", C_JUMP,  3, '{0, 1, 9, 0, 0}); endtask

  task automatic testUnknown();
    runPath("R9", 6'b111111, 2, '{0, 1, 0, 0, 0});
    checkStep("R9", 0);
    runPath("R9", 6'b001000, 2, '{0, 1, 0, 0, 0});
    checkStep("R2", 0);
  endtask

  task automatic testIgnoredOpcode();
    opcode = C_BEQ;          // fetch: ignored
    checkStep("R8", 0);
    @(negedge clk);
    opcode = C_LOAD;         // decode: consulted
    checkStep("R8", 1);
    @(negedge clk);
    checkStep("R8", 2);      // address: still load
    @(negedge clk);
    opcode = C_JUMP;         // read step: ignored
    checkStep("R8", 3);
    @(negedge clk);
    opcode = C_RTYPE;        // write-back: ignored
    checkStep("R8", 4);
    @(negedge clk);
    checkStep("R8", 0);
  endtask

  task automatic testMidReset();
    opcode = C_LOAD;
    checkStep("R1", 0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    checkStep("R1", 3);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkStep("R1", 0);
    @(negedge clk);
    checkStep("R1", 1);
    @(negedge clk);
    checkStep("R1", 2);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      finishRun();
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testLoad();
    testStore();
    testRtype();
    testBranch();
    testJump();
    testLoad();
    testJump();
    testStore();
    testUnknown();
    testIgnoredOpcode();
    testMidReset();
    testBranch();
    testRtype();
    checkStep("R2", 0);
    finishRun();
  end

endmodule